// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects interrupt request pulses from a set of external and internal sources into sticky flags and raises one general request line to the CPU. Each flag latches whenever its source pulses, whether or not the source is masked. The CPU request is asserted while a general enable is on and at least one set flag has its mask bit open. Vectoring and context saving stay with the CPU.

Software reaches the flags, the masks and the general enable through a small register port. The flags and the masks are grouped into banks of `BANK_W` bits. Writing a one to a flag bit clears that flag. Reading a flag bank clears every flag it returned. A request that arrives in the same cycle as a clear keeps its flag set, so no event is lost. The general enable is switched on by hardware on the rising edge of the CPU halt indication, so a halted CPU can always be woken.

Sources are numbered with external inputs first (`req_ext[k]` is source k) and internal inputs after them (`req_int[j]` is source `N_EXT+j`). Source s sits in bank `s / BANK_W`, bit `s % BANK_W`. With the defaults (5 external, 8 internal, 4-bit banks) there are 13 sources in 4 banks. The register address is 4 bits wide:
- flag banks are at addresses 0 to 3;
- mask banks are at addresses 4 to 7;
- the control register is at address 8.

Top module: `irq_gather`

## Requirements
- R1: After reset, all flags, all masks and the general enable are 0, `cpu_irq` is 0, and every register reads 0.
- R2: A source request high at a clock edge sets its flag from that edge on, whatever its mask or the general enable. The flag of source s reads at address `s / 4`, bit `s % 4` (external k is source k; internal j is source 5+j).
- R3: A write to a flag bank address clears the flags whose write-data bits are 1 and leaves the flags whose bits are 0 unchanged.
- R4: A read strobe (`reg_rd` high) on a flag bank address returns the current flags combinationally and clears, at that clock edge, every flag that was returned as 1.
- R5: A request arriving in the same cycle as a clear of its flag, whether by read or by write, leaves the flag set.
- R6: Mask bank b is at address 4+b; mask bit 1 lets its source reach `cpu_irq`. Bits with no source (sources 13 to 15) read 0 in both the flag banks and the mask banks, even after writing ones.
- R7: Bit 0 of the control register (address 8) is the general enable. A write loads it, and a read returns it with the upper bits 0.
- R8: `cpu_irq` is 1 exactly when the general enable is 1 and some flag and its mask bit are both 1. It follows state changes in the cycle after the edge that made them.
- R9: A rising edge of `cpu_halt` sets the general enable at that clock edge. This wins over a write of 0 to the control register in the same cycle, and a halt held high does not set it again.
- R10: Addresses 9 to 15 read 0 and writes to them change nothing. Reads of the mask and control addresses have no side effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_ext | input | N_EXT | External request pulses, sources 0..N_EXT-1 |
| req_int | input | N_INT | Internal request pulses, sources N_EXT.. |
| reg_addr | input | ADDR_W | Register address (4 by default) |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | BANK_W | Write data |
| reg_rd | input | 1 | Read strobe (clears flags read) |
| reg_rdata | output | BANK_W | Read data for `reg_addr` (combinational) |
| cpu_halt | input | 1 | CPU halt indication (level) |
| cpu_irq | output | 1 | General interrupt request to the CPU |

## Verification
The assertions assume that every input is a clean synchronous level sampled at the rising clock. They also assume that a flag can only drop in a cycle after a read or write strobe, so the register strobes must be single-cycle per access and never carry unknown values. The stimulus drives all inputs on the falling edge from the bench, mixes directed sequences with random traffic over the whole address range, and pulses the halt line with both short and held-high patterns. That way the edge detection and the read-clear and request collisions all occur.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
   typedef enum logic [1:0] {
      GRP_FLAG = 2'd0,
      GRP_MASK = 2'd1,
      GRP_CTRL = 2'd2,
      GRP_NONE = 2'd3
   } reg_grp_e;
endpackage

// File: rtl/irqg_flag_bank.sv
module irqg_flag_bank #(
   parameter int BANK_W = 4,
   parameter int VALID  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] req,
   input  logic              wr_clr,
   input  logic [BANK_W-1:0] wdata,
   input  logic              rd_clr,
   output logic [BANK_W-1:0] flags
);
   logic [BANK_W-1:0] clr_mask;

   always_comb begin
      clr_mask = '0;
      if (wr_clr) clr_mask = clr_mask | wdata;
      if (rd_clr) clr_mask = clr_mask | flags;
   end

   for (genvar b = 0; b < BANK_W; b++) begin : g_bit
      if (b < VALID) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flags[b] <= 1'b0;
            else        flags[b] <= (flags[b] & ~clr_mask[b]) | req[b];
         end
      end else begin : g_tie
         assign flags[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irqg_mask_bank.sv
module irqg_mask_bank #(
   parameter int BANK_W = 4,
   parameter int VALID  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] mask
);
   for (genvar b = 0; b < BANK_W; b++) begin : g_bit
      if (b < VALID) begin : g_live
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)  mask[b] <= 1'b0;
            else if (wr) mask[b] <= wdata[b];
         end
      end else begin : g_tie
         assign mask[b] = 1'b0;
      end
   end
endmodule

// File: rtl/irqg_enable.sv
module irqg_enable (
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   input  logic wr,
   input  logic wbit,
   output logic gen_en
);
   logic halt_q;
   logic halt_rise;

   assign halt_rise = halt & ~halt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halt_q <= 1'b0;
         gen_en <= 1'b0;
      end else begin
         halt_q <= halt;
         if (halt_rise) gen_en <= 1'b1;
         else if (wr)   gen_en <= wbit;
      end
   end
endmodule

// File: rtl/irq_gather.sv
module irq_gather #(
   parameter  int N_EXT   = 5,
   parameter  int N_INT   = 8,
   parameter  int BANK_W  = 4,
   localparam int N_SRC   = N_EXT + N_INT,
   localparam int NBANK   = (N_SRC + BANK_W - 1) / BANK_W,
   localparam int BANK_AW = (NBANK > 1) ? $clog2(NBANK) : 1,
   localparam int ADDR_W  = BANK_AW + 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_EXT-1:0]  req_ext,
   input  logic [N_INT-1:0]  req_int,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [BANK_W-1:0] reg_wdata,
   input  logic              reg_rd,
   output logic [BANK_W-1:0] reg_rdata,
   input  logic              cpu_halt,
   output logic              cpu_irq
);
   import irqg_pkg::*;

   localparam int N_PAD = NBANK * BANK_W;

   if (N_EXT < 1) begin : g_bad_ext
      $error("irq_gather: N_EXT must be at least 1");
   end
   if (N_INT < 1) begin : g_bad_int
      $error("irq_gather: N_INT must be at least 1");
   end
   if (BANK_W < 1) begin : g_bad_bw
      $error("irq_gather: BANK_W must be at least 1");
   end

   logic [N_PAD-1:0]   req_pad;
   logic [N_PAD-1:0]   flag_q;
   logic [N_PAD-1:0]   mask_q;
   logic               gen_en;
   reg_grp_e           grp;
   logic [BANK_AW-1:0] bank;
   logic               bank_ok;

   if (N_PAD > N_SRC) begin : g_pad
      assign req_pad = {{(N_PAD-N_SRC){1'b0}}, req_int, req_ext};
   end else begin : g_nopad
      assign req_pad = {req_int, req_ext};
   end

   assign grp     = reg_grp_e'(reg_addr[ADDR_W-1 -: 2]);
   assign bank    = reg_addr[BANK_AW-1:0];
   assign bank_ok = (int'(bank) < NBANK);

   for (genvar k = 0; k < NBANK; k++) begin : g_bank
      localparam int REM   = N_SRC - k * BANK_W;
      localparam int VALID = (REM < BANK_W) ? REM : BANK_W;
      logic hit;
      assign hit = (int'(bank) == k);

      irqg_flag_bank #(.BANK_W(BANK_W), .VALID(VALID)) u_flag (
         .clk    (clk),
         .rst_n  (rst_n),
         .req    (req_pad[k*BANK_W +: BANK_W]),
         .wr_clr (reg_wr && grp == GRP_FLAG && hit),
         .wdata  (reg_wdata),
         .rd_clr (reg_rd && grp == GRP_FLAG && hit),
         .flags  (flag_q[k*BANK_W +: BANK_W])
      );

      irqg_mask_bank #(.BANK_W(BANK_W), .VALID(VALID)) u_mask (
         .clk   (clk),
         .rst_n (rst_n),
         .wr    (reg_wr && grp == GRP_MASK && hit),
         .wdata (reg_wdata),
         .mask  (mask_q[k*BANK_W +: BANK_W])
      );
   end

   irqg_enable u_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .halt   (cpu_halt),
      .wr     (reg_wr && grp == GRP_CTRL && bank == '0),
      .wbit   (reg_wdata[0]),
      .gen_en (gen_en)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (grp)
         GRP_FLAG: if (bank_ok) reg_rdata = flag_q[int'(bank)*BANK_W +: BANK_W];
         GRP_MASK: if (bank_ok) reg_rdata = mask_q[int'(bank)*BANK_W +: BANK_W];
         GRP_CTRL: if (bank == '0) reg_rdata[0] = gen_en;
         default:  reg_rdata = '0;
      endcase
   end

   assign cpu_irq = gen_en & (|(flag_q & mask_q));
endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
   parameter int N_PAD = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_PAD-1:0] req_pad,
   input logic [N_PAD-1:0] flag_q,
   input logic [N_PAD-1:0] mask_q,
   input logic             gen_en,
   input logic             cpu_halt,
   input logic             cpu_irq,
   input logic             reg_rd,
   input logic             reg_wr
);
   // R2 / R5: a request always lands in its flag
   p_req_latched_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((flag_q & $past(req_pad)) == $past(req_pad)));

   // R3 / R4: flags only drop after a register access
   p_drop_needs_access_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (($past(flag_q) & ~flag_q) != '0) |-> $past(reg_rd | reg_wr));

   // R8: request needs the general enable
   p_irq_needs_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> gen_en);

   // R8: request needs an unmasked set flag
   p_irq_needs_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq |-> ((flag_q & mask_q) != '0));

   // R9: halt rising edge turns the enable on
   p_halt_enables_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_halt) |=> gen_en);

   // R10: masks move only on a write
   p_mask_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(reg_wr) |-> $stable(mask_q));
endmodule

bind irq_gather irq_gather_chk #(.N_PAD(N_PAD)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .req_pad  (req_pad),
   .flag_q   (flag_q),
   .mask_q   (mask_q),
   .gen_en   (gen_en),
   .cpu_halt (cpu_halt),
   .cpu_irq  (cpu_irq),
   .reg_rd   (reg_rd),
   .reg_wr   (reg_wr)
);

// File: tb/irq_gather_bench.sv
`timescale 1ns/100ps
module irq_gather_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] req_ext = '0;
   logic [7:0] req_int = '0;
   logic [3:0] reg_addr = '0;
   logic       reg_wr = 1'b0;
   logic [3:0] reg_wdata = '0;
   logic       reg_rd = 1'b0;
   logic [3:0] reg_rdata;
   logic       cpu_halt = 1'b0;
   logic       cpu_irq;

   int total = 0;
   int bad = 0;

   // reference model state
   logic [15:0] m_flag, m_mask;
   bit          m_ge, m_hp;
   localparam logic [15:0] VALID = 16'h1FFF;

   always #2.5 clk = ~clk;

   irq_gather u_irq_gather (
      .clk(clk), .rst_n(rst_n), .req_ext(req_ext), .req_int(req_int),
      .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rd(reg_rd), .reg_rdata(reg_rdata), .cpu_halt(cpu_halt),
      .cpu_irq(cpu_irq)
   );

   function automatic logic [3:0] exp_read(input int a);
      if (a < 4)       return m_flag[a*4 +: 4];
      else if (a < 8)  return m_mask[(a-4)*4 +: 4];
      else if (a == 8) return {3'b000, m_ge};
      return 4'h0;
   endfunction

   task automatic step(input string tag, input logic [4:0] e, input logic [7:0] i,
                       input int a, input bit w, input logic [3:0] d,
                       input bit r, input bit h);
      logic [15:0] req, clr;
      logic [3:0]  xr;
      bit          xi;
      req_ext = e; req_int = i; reg_addr = 4'(a); reg_wr = w;
      reg_wdata = d; reg_rd = r; cpu_halt = h;
      #1;
      xr = exp_read(a);
      xi = m_ge && ((m_flag & m_mask) != 16'h0);
      total++;
      if (reg_rdata !== xr) begin
         bad++;
         $display("FAIL %s rdata addr=%0d actual=%h expected=%h", tag, a, reg_rdata, xr);
      end
      total++;
      if (cpu_irq !== xi) begin
         bad++;
         $display("FAIL %s cpu_irq actual=%b expected=%b", tag, cpu_irq, xi);
      end
      @(posedge clk);
      req = {3'b000, i, e};
      clr = '0;
      if (w && a < 4) clr[a*4 +: 4] = d;
      if (r && a < 4) clr[a*4 +: 4] = clr[a*4 +: 4] | m_flag[a*4 +: 4];
      m_flag = ((m_flag & ~clr) | req) & VALID;
      if (w && a >= 4 && a < 8) m_mask[(a-4)*4 +: 4] = d;
      m_mask = m_mask & VALID;
      if (h && !m_hp) m_ge = 1'b1;
      else if (w && a == 8) m_ge = d[0];
      m_hp = h;
      @(negedge clk);
   endtask

   initial begin
      #100000;
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      m_flag = '0; m_mask = '0; m_ge = 0; m_hp = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      for (int a = 0; a < 16; a++) step("R1", 0, 0, a, 0, 0, 0, 0);
      // R2 masked, disabled requests still latch
      step("R2", 5'b00100, 0, 0, 0, 0, 0, 0);
      step("R2", 0, 0, 0, 0, 0, 0, 0);
      step("R2", 0, 8'h08, 2, 0, 0, 0, 0);
      step("R2", 0, 0, 2, 0, 0, 0, 0);
      step("R2", 5'b10001, 8'h80, 1, 0, 0, 0, 0);
      step("R2", 0, 0, 3, 0, 0, 0, 0);
      // R3 write-one clear, zeros untouched
      step("R3", 0, 0, 0, 1, 4'b0100, 0, 0);
      step("R3", 0, 0, 0, 0, 0, 0, 0);
      step("R3", 0, 0, 1, 0, 0, 0, 0);
      // R6 masks, padding bits read 0
      step("R6", 0, 0, 6, 1, 4'h1, 0, 0);
      step("R6", 0, 0, 7, 1, 4'hF, 0, 0);
      step("R6", 0, 0, 7, 0, 0, 0, 0);
      step("R6", 0, 0, 6, 0, 0, 0, 0);
      // R7 / R8 enable and request
      step("R8", 0, 0, 8, 1, 4'h1, 0, 0);
      step("R7", 0, 0, 8, 0, 0, 0, 0);
      step("R8", 0, 0, 2, 0, 0, 0, 0);
      // R4 read clears
      step("R4", 0, 0, 2, 0, 0, 1, 0);
      step("R4", 0, 0, 2, 0, 0, 0, 0);
      step("R4", 0, 0, 3, 0, 0, 1, 0);
      step("R4", 0, 0, 3, 0, 0, 0, 0);
      // R5 collisions with read clear and write clear
      step("R5", 0, 8'h08, 2, 0, 0, 0, 0);
      step("R5", 0, 8'h08, 2, 0, 0, 1, 0);
      step("R5", 0, 0, 2, 0, 0, 0, 0);
      step("R5", 0, 8'h08, 2, 1, 4'h1, 0, 0);
      step("R5", 0, 0, 2, 0, 0, 0, 0);
      // R9 halt edge beats write of 0; held halt does not re-set
      step("R9", 0, 0, 8, 1, 4'h0, 0, 0);
      step("R9", 0, 0, 8, 1, 4'h0, 0, 1);
      step("R9", 0, 0, 8, 1, 4'h0, 0, 1);
      step("R9", 0, 0, 8, 0, 0, 0, 1);
      step("R9", 0, 0, 8, 0, 0, 0, 0);
      step("R9", 0, 0, 8, 0, 0, 0, 1);
      step("R9", 0, 0, 8, 0, 0, 0, 0);
      // R10 unmapped and side-effect-free reads
      step("R10", 0, 0, 12, 1, 4'hF, 0, 0);
      step("R10", 0, 0, 9, 1, 4'hF, 1, 0);
      step("R10", 0, 0, 6, 0, 0, 1, 0);
      step("R10", 0, 0, 8, 0, 0, 1, 0);
      step("R10", 0, 0, 2, 0, 0, 0, 0);
      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic [4:0] e;
         logic [7:0] i;
         e = ($urandom_range(0, 3) == 0) ? 5'($urandom) : 5'h0;
         i = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'h0;
         step("R8", e, i, $urandom_range(0, 15), ($urandom_range(0, 3) == 0),
              4'($urandom), ($urandom_range(0, 2) == 0),
              ($urandom_range(0, 5) == 0));
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule